// File: doc/BRIEF.md
# Bit-17 Page Swizzle Repair Engine

This engine keeps a one-bit-per-page history of physical address bit 17 for a buffer made of 4 KiB pages. It also repairs page contents when a page comes back at a physical location with a different bit 17. Some memory controllers fold address bit 17 into their channel interleave. For such a page, the two 64-byte halves of every 128-byte chunk appear swapped once the page has moved. The engine undoes this by exchanging those halves in place.

Each command carries an operation (record or repair) and a page count. Page frame numbers then arrive one per valid/ready handshake, in page order. For a record operation, the engine stores the frame's bit 17 in the history at that page's position. For a repair operation, it reads the stored bit and compares it with the new frame's bit 17. On a mismatch it rewrites the page through a 64-bit word port to page memory and reports the page index as dirty. A one-cycle done pulse closes every command. Page counts above the history depth are refused with an error flag.

Top module: `swz17_fixup`

## Requirements
- R1: A record command stores bit 5 of each frame number (physical address bit 17 with 4 KiB pages) into the history at that page's index. A repair command never changes the history, so repeating the same repair swaps the same pages again.
- R2: In a repair command, a page whose frame bit 5 equals its stored bit causes no memory request and no dirty report.
- R3: In a repair command, a page whose frame bit 5 differs from its stored bit is rewritten so that, for every word index w (0..511) of the page, the new word at w equals the old word at w XOR 8. Word address = {frame number, 9-bit word index}.
- R4: Every rewritten page is reported exactly once by a one-cycle dirty_valid pulse carrying its page index. Pages that were not rewritten are never reported.
- R5: A repair command issued before any record command accepts no frame number, makes no memory request and ends with done.
- R6: A command whose page count exceeds 256 accepts no frame number and pulses done together with err. The history is left unchanged.
- R7: One frame number is taken per cycle in which pfn_valid and pfn_ready are both high. Exactly page-count numbers are taken. done is a single-cycle pulse after the last page. cmd_ready is high only while idle, and never together with pfn_ready.
- R8: A page count of zero ends with done and takes no frame number.
- R9: After reset, cmd_ready is 1 and pfn_ready, mem_req, done and err are 0. The history counts as never recorded.
- R10: A command with the maximum count of 256 pages is accepted, and the page at index 255 is compared and repaired like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when both high |
| cmd_mode | input | 1 | 0 = record, 1 = repair |
| cmd_pages | input | 9 | Page count (0..511, above 256 refused) |
| pfn_valid | input | 1 | Frame number offered |
| pfn_ready | output | 1 | Engine wants the next frame number |
| pfn_data | input | 20 | Page frame number |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 29 | Word address {frame, word index} |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle command completion pulse |
| err | output | 1 | High with done when the command was refused |
| dirty_valid | output | 1 | One-cycle pulse per rewritten page |
| dirty_page | output | 8 | Index of the rewritten page |

## Verification
The hardest state to reach is a repair in which matching and mismatching pages are interleaved. That only happens after a record pass with a chosen bit pattern, followed by a repair pass with frame numbers whose bit 5 is flipped for selected pages. The bench records a mixed pattern first and then repairs with two pages flipped, so traffic, dirty reports and page contents can be compared page by page. It then repeats the same repair to show that the history survived and the pages return to their original layout. A 256-page pass with only the last page flipped reaches the top history index.

// File: rtl/swz17_pkg.sv
package swz17_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TAKE,
    ST_LOOK,
    ST_RDLO,
    ST_RDHI,
    ST_WRLO,
    ST_WRHI,
    ST_ADV,
    ST_FIN
  } swz_state_t;

  typedef enum logic {
    OP_RECORD = 1'b0,
    OP_REPAIR = 1'b1
  } swz_op_t;

endpackage

// File: rtl/swz17_hist_ram.sv
module swz17_hist_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);

  logic store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wbit;
    rbit <= store[raddr];
  end

endmodule

// File: rtl/swz17_half_buf.sv
module swz17_half_buf #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 8,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/swz17_ctrl.sv
module swz17_ctrl
  import swz17_pkg::*;
#(
  parameter int PFN_W     = 20,
  parameter int SEL_BIT   = 5,
  parameter int MAX_PAGES = 256,
  parameter int PIDX_W    = 8,
  parameter int CNT_W     = 9,
  parameter int CH_W      = 5,
  parameter int HW_W      = 3,
  parameter int ADDR_W    = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_mode,
  input  logic [CNT_W-1:0]  cmd_pages,
  output logic              cmd_ready,
  input  logic              pfn_valid,
  input  logic [PFN_W-1:0]  pfn_data,
  output logic              pfn_ready,
  output logic              hist_we,
  output logic [PIDX_W-1:0] hist_addr,
  output logic              hist_wbit,
  input  logic              hist_rbit,
  output logic              buf_we,
  output logic [HW_W-1:0]   buf_waddr,
  output logic [HW_W-1:0]   buf_raddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wsel_buf,
  output logic              done,
  output logic              err,
  output logic              dirty_valid,
  output logic [PIDX_W-1:0] dirty_page
);

  localparam logic [CH_W-1:0] LAST_CH = {CH_W{1'b1}};
  localparam logic [HW_W-1:0] LAST_HW = {HW_W{1'b1}};

  swz_state_t        state_q;
  swz_op_t           op_q;
  logic [CNT_W-1:0]  npages_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              cur_bit_q;
  logic [CH_W-1:0]   chunk_q;
  logic [HW_W-1:0]   hw_q;
  logic              recorded_q;
  logic              err_q;
  logic              dirty_q;
  logic [PIDX_W-1:0] dirty_idx_q;
  logic              cap_q;
  logic [HW_W-1:0]   cap_idx_q;
  logic              last_page;
  logic              half_sel;

  assign last_page = ({1'b0, pidx_q} == (npages_q - CNT_W'(1)));

  assign cmd_ready = (state_q == ST_IDLE);
  assign pfn_ready = (state_q == ST_TAKE);

  assign hist_we   = (state_q == ST_TAKE) && pfn_valid && (op_q == OP_RECORD);
  assign hist_addr = pidx_q;
  assign hist_wbit = pfn_data[SEL_BIT];

  assign buf_we    = cap_q;
  assign buf_waddr = cap_idx_q;
  assign buf_raddr = hw_q;

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    half_sel = 1'b0;
    wsel_buf = 1'b0;
    unique case (state_q)
      ST_RDLO: begin mem_req = 1'b1; end
      ST_RDHI: begin mem_req = 1'b1; half_sel = 1'b1; end
      ST_WRLO: begin mem_req = 1'b1; mem_we = 1'b1; end
      ST_WRHI: begin mem_req = 1'b1; mem_we = 1'b1; half_sel = 1'b1; wsel_buf = 1'b1; end
      default: ;
    endcase
  end

  assign mem_addr = {pfn_q, chunk_q, half_sel, hw_q};

  assign done        = (state_q == ST_FIN);
  assign err         = err_q;
  assign dirty_valid = dirty_q;
  assign dirty_page  = dirty_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_RECORD;
      npages_q    <= '0;
      pidx_q      <= '0;
      pfn_q       <= '0;
      cur_bit_q   <= 1'b0;
      chunk_q     <= '0;
      hw_q        <= '0;
      recorded_q  <= 1'b0;
      err_q       <= 1'b0;
      dirty_q     <= 1'b0;
      dirty_idx_q <= '0;
      cap_q       <= 1'b0;
      cap_idx_q   <= '0;
    end else begin
      dirty_q   <= 1'b0;
      cap_q     <= (state_q == ST_RDLO);
      cap_idx_q <= hw_q;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q     <= swz_op_t'(cmd_mode);
            npages_q <= cmd_pages;
            pidx_q   <= '0;
            if (cmd_pages > CNT_W'(MAX_PAGES)) begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end else if (cmd_pages == '0) begin
              state_q <= ST_FIN;
            end else if ((swz_op_t'(cmd_mode) == OP_REPAIR) && !recorded_q) begin
              state_q <= ST_FIN;
            end else begin
              state_q <= ST_TAKE;
            end
          end
        end
        ST_TAKE: begin
          if (pfn_valid) begin
            pfn_q     <= pfn_data;
            cur_bit_q <= pfn_data[SEL_BIT];
            if (op_q == OP_RECORD) begin
              recorded_q <= 1'b1;
              if (last_page) state_q <= ST_FIN;
              else           pidx_q  <= pidx_q + PIDX_W'(1);
            end else begin
              state_q <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          chunk_q <= '0;
          hw_q    <= '0;
          if (hist_rbit != cur_bit_q) state_q <= ST_RDLO;
          else                        state_q <= ST_ADV;
        end
        ST_RDLO: begin
          if (hw_q == LAST_HW) begin
            hw_q    <= '0;
            state_q <= ST_RDHI;
          end else begin
            hw_q <= hw_q + HW_W'(1);
          end
        end
        ST_RDHI: state_q <= ST_WRLO;
        ST_WRLO: state_q <= ST_WRHI;
        ST_WRHI: begin
          if (hw_q == LAST_HW) begin
            hw_q <= '0;
            if (chunk_q == LAST_CH) begin
              dirty_q     <= 1'b1;
              dirty_idx_q <= pidx_q;
              state_q     <= ST_ADV;
            end else begin
              chunk_q <= chunk_q + CH_W'(1);
              state_q <= ST_RDLO;
            end
          end else begin
            hw_q    <= hw_q + HW_W'(1);
            state_q <= ST_RDHI;
          end
        end
        ST_ADV: begin
          if (last_page) begin
            state_q <= ST_FIN;
          end else begin
            pidx_q  <= pidx_q + PIDX_W'(1);
            state_q <= ST_TAKE;
          end
        end
        ST_FIN: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swz17_fixup.sv
module swz17_fixup #(
  parameter int PFN_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int PHYS_BIT   = 17,
  parameter int DATA_W     = 64,
  parameter int CHUNK_B    = 128,
  parameter int MAX_PAGES  = 256,
  localparam int WORD_B    = DATA_W / 8,
  localparam int PAGE_B    = 1 << PAGE_SHIFT,
  localparam int WIDX_W    = $clog2(PAGE_B / WORD_B),
  localparam int HALF_W    = CHUNK_B / 2 / WORD_B,
  localparam int HW_W      = $clog2(HALF_W),
  localparam int CH_W      = $clog2(PAGE_B / CHUNK_B),
  localparam int PIDX_W    = $clog2(MAX_PAGES),
  localparam int CNT_W     = PIDX_W + 1,
  localparam int ADDR_W    = PFN_W + WIDX_W,
  localparam int SEL_BIT   = PHYS_BIT - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_mode,
  input  logic [CNT_W-1:0]  cmd_pages,
  input  logic              pfn_valid,
  output logic              pfn_ready,
  input  logic [PFN_W-1:0]  pfn_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic              dirty_valid,
  output logic [PIDX_W-1:0] dirty_page
);

  logic              hist_we;
  logic [PIDX_W-1:0] hist_addr;
  logic              hist_wbit;
  logic              hist_rbit;
  logic              buf_we;
  logic [HW_W-1:0]   buf_waddr;
  logic [HW_W-1:0]   buf_raddr;
  logic [DATA_W-1:0] buf_rdata;
  logic              wsel_buf;

  swz17_ctrl #(
    .PFN_W    (PFN_W),
    .SEL_BIT  (SEL_BIT),
    .MAX_PAGES(MAX_PAGES),
    .PIDX_W   (PIDX_W),
    .CNT_W    (CNT_W),
    .CH_W     (CH_W),
    .HW_W     (HW_W),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_mode   (cmd_mode),
    .cmd_pages  (cmd_pages),
    .cmd_ready  (cmd_ready),
    .pfn_valid  (pfn_valid),
    .pfn_data   (pfn_data),
    .pfn_ready  (pfn_ready),
    .hist_we    (hist_we),
    .hist_addr  (hist_addr),
    .hist_wbit  (hist_wbit),
    .hist_rbit  (hist_rbit),
    .buf_we     (buf_we),
    .buf_waddr  (buf_waddr),
    .buf_raddr  (buf_raddr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .wsel_buf   (wsel_buf),
    .done       (done),
    .err        (err),
    .dirty_valid(dirty_valid),
    .dirty_page (dirty_page)
  );

  swz17_hist_ram #(
    .DEPTH(MAX_PAGES),
    .AW   (PIDX_W)
  ) u_hist (
    .clk  (clk),
    .we   (hist_we),
    .waddr(hist_addr),
    .wbit (hist_wbit),
    .raddr(hist_addr),
    .rbit (hist_rbit)
  );

  swz17_half_buf #(
    .DATA_W(DATA_W),
    .WORDS (HALF_W),
    .AW    (HW_W)
  ) u_buf (
    .clk  (clk),
    .we   (buf_we),
    .waddr(buf_waddr),
    .wdata(mem_rdata),
    .raddr(buf_raddr),
    .rdata(buf_rdata)
  );

  assign mem_wdata = wsel_buf ? buf_rdata : mem_rdata;

endmodule

// File: rtl/swz17_fixup_chk.sv
module swz17_fixup_chk (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic pfn_ready,
  input logic mem_req,
  input logic mem_we,
  input logic done,
  input logic err,
  input logic dirty_valid
);

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  ready_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    pfn_ready |-> !cmd_ready);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R4
  dirty_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    dirty_valid |-> $past(mem_req && mem_we));

  // R2
  no_idle_traffic_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !(cmd_ready || pfn_ready));

endmodule

bind swz17_fixup swz17_fixup_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .pfn_ready  (pfn_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .done       (done),
  .err        (err),
  .dirty_valid(dirty_valid)
);

// File: tb/swz17_fixup_bench.sv
module swz17_fixup_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_mode = 1'b0;
  logic [8:0]  cmd_pages = '0;
  logic        pfn_valid = 1'b0;
  logic        pfn_ready;
  logic [19:0] pfn_data = '0;
  logic        mem_req;
  logic        mem_we;
  logic [28:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic        err;
  logic        dirty_valid;
  logic [7:0]  dirty_page;

  always #2 clk = ~clk;

  swz17_fixup u_swz17_fixup (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode), .cmd_pages(cmd_pages),
    .pfn_valid(pfn_valid), .pfn_ready(pfn_ready), .pfn_data(pfn_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err), .dirty_valid(dirty_valid), .dirty_page(dirty_page)
  );

  int checks = 0;
  int errors = 0;

  logic [63:0] pmem [4096];
  logic [19:0] pfns [256];

  int  traffic;
  int  dirty_cnt;
  int  done_cnt;
  logic [7:0] last_dirty;
  logic dirty_seen [256];

  function automatic int slot_of(logic [19:0] p);
    return int'({p[5], p[1:0]});
  endfunction

  function automatic logic [63:0] pat(int s, int w);
    return {24'h5A5A5A, 8'(s), 23'd0, 9'(w)};
  endfunction

  function automatic logic [19:0] mk_pfn(int p, bit b);
    return 20'h40000 | (20'(b) << 5) | 20'(p & 3);
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      traffic <= traffic + 1;
      if (mem_we) pmem[slot_of(mem_addr[28:9]) * 512 + int'(mem_addr[8:0])] <= mem_wdata;
      else        mem_rdata <= pmem[slot_of(mem_addr[28:9]) * 512 + int'(mem_addr[8:0])];
    end
    if (dirty_valid) begin
      dirty_cnt <= dirty_cnt + 1;
      last_dirty <= dirty_page;
      dirty_seen[dirty_page] <= 1'b1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 512; w++) pmem[s * 512 + w] = pat(s, w);
  endtask

  task automatic clear_mon();
    @(negedge clk);
    traffic = 0; dirty_cnt = 0; done_cnt = 0;
    for (int i = 0; i < 256; i++) dirty_seen[i] = 1'b0;
  endtask

  task automatic check_page(input int s, input bit swapped, input string tag);
    int bad = 0;
    int first = -1;
    for (int w = 0; w < 512; w++) begin
      logic [63:0] e;
      e = swapped ? pat(s, w ^ 8) : pat(s, w);
      if (pmem[s * 512 + w] !== e) begin
        bad++;
        if (first < 0) first = w;
      end
    end
    check(bad == 0, tag, bad, 0);
    if (bad != 0) $display("  first bad word %0d of slot %0d", first, s);
  endtask

  task automatic run_op(input bit mode, input int n, output int taken, output bit saw_err);
    bit got = 0;
    bit take = 0;
    int cyc = 0;
    taken = 0; saw_err = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = mode; cmd_pages = 9'(n);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!got && cyc < 40000) begin
      if (take) taken++;
      if (done) begin
        got = 1; saw_err = err; pfn_valid = 1'b0; take = 0;
      end else begin
        pfn_valid = (taken < n && taken < 256);
        pfn_data  = pfns[taken & 255];
        take = pfn_valid && pfn_ready;
        @(negedge clk);
        cyc++;
      end
    end
    pfn_valid = 1'b0;
    check(got, "R7 watchdog done seen", got, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cmd_ready === 1'b1, "R9 cmd_ready after reset", cmd_ready, 1);
    check(pfn_ready === 1'b0 && mem_req === 1'b0, "R9 idle outputs", {pfn_ready, mem_req}, 0);
    check(done === 1'b0 && err === 1'b0, "R9 done/err low", {done, err}, 0);
  endtask

  task automatic t_repair_first();
    int tk; bit e;
    for (int p = 0; p < 3; p++) pfns[p] = mk_pfn(p, 1);
    clear_mon();
    run_op(1'b1, 3, tk, e);
    check(tk == 0, "R5 no frame taken before record", tk, 0);
    check(traffic == 0, "R5 no traffic before record", traffic, 0);
    check(done_cnt == 1 && !e, "R5 done without err", done_cnt, 1);
  endtask

  task automatic t_record();
    int tk; bit e;
    for (int p = 0; p < 4; p++) pfns[p] = mk_pfn(p, p[0]);
    clear_mon();
    run_op(1'b0, 4, tk, e);
    check(tk == 4, "R7 record takes page count", tk, 4);
    check(traffic == 0, "R1 record makes no traffic", traffic, 0);
    check(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
  endtask

  task automatic t_repair_match();
    int tk; bit e;
    clear_mon();
    run_op(1'b1, 4, tk, e);
    check(tk == 4, "R7 repair takes page count", tk, 4);
    check(traffic == 0, "R2 matching pages no traffic", traffic, 0);
    check(dirty_cnt == 0, "R2 matching pages no dirty", dirty_cnt, 0);
    for (int s = 0; s < 8; s++) check_page(s, 0, "R2 memory untouched");
  endtask

  task automatic t_repair_flip(input bit second);
    int tk; bit e;
    pfns[0] = mk_pfn(0, 0);
    pfns[1] = mk_pfn(1, 0);
    pfns[2] = mk_pfn(2, 1);
    pfns[3] = mk_pfn(3, 1);
    clear_mon();
    run_op(1'b1, 4, tk, e);
    check(traffic == 2048, "R3 traffic for two pages", traffic, 2048);
    check(dirty_cnt == 2, "R4 two dirty pulses", dirty_cnt, 2);
    check(dirty_seen[1] && dirty_seen[2] && !dirty_seen[0] && !dirty_seen[3],
          "R4 dirty indices 1 and 2", {dirty_seen[0], dirty_seen[1], dirty_seen[2], dirty_seen[3]}, 6);
    check_page(1, !second, second ? "R1 history kept page1 restored" : "R3 page1 halves swapped");
    check_page(6, !second, second ? "R1 history kept page2 restored" : "R3 page2 halves swapped");
    check_page(0, 0, "R2 page0 untouched");
    check_page(7, 0, "R2 page3 untouched");
  endtask

  task automatic t_overflow();
    int tk; bit e;
    clear_mon();
    run_op(1'b0, 257, tk, e);
    check(e, "R6 err with done", e, 1);
    check(tk == 0, "R6 no frame taken", tk, 0);
    for (int p = 0; p < 4; p++) pfns[p] = mk_pfn(p, p[0]);
    clear_mon();
    run_op(1'b1, 4, tk, e);
    check(traffic == 0 && !e, "R6 history unchanged", traffic, 0);
  endtask

  task automatic t_zero();
    int tk; bit e;
    clear_mon();
    run_op(1'b0, 0, tk, e);
    check(tk == 0 && done_cnt == 1 && !e, "R8 zero pages", tk, 0);
  endtask

  task automatic t_full();
    int tk; bit e;
    for (int p = 0; p < 256; p++) pfns[p] = mk_pfn(p, 0);
    clear_mon();
    run_op(1'b0, 256, tk, e);
    check(tk == 256 && !e, "R10 record 256 pages", tk, 256);
    mem_init();
    pfns[255] = mk_pfn(3, 1);
    clear_mon();
    run_op(1'b1, 256, tk, e);
    check(tk == 256, "R10 repair takes 256", tk, 256);
    check(dirty_cnt == 1 && last_dirty == 8'd255, "R10 dirty index 255", last_dirty, 255);
    check_page(7, 1, "R10 last page swapped");
    check_page(3, 0, "R10 matching page untouched");
  endtask

  initial begin
    mem_init();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_repair_first();
    t_record();
    t_repair_match();
    t_repair_flip(0);
    t_repair_flip(1);
    t_overflow();
    t_zero();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule